// File: doc/BRIEF.md
# Viterbi Compare-Select with Traceback

This block chooses the larger or smaller of two 40-bit accumulator operands, treating each operand either as one signed 40-bit value or as two independent signed 16-bit lanes. It serves the add-compare-select step of a Viterbi decoder: after the path metrics are summed elsewhere, one operation picks the surviving metric and records the decision. The winner of each comparison is registered and presented at `res`.

In the decoder form, each decision is pushed into a 16-bit traceback shift register in the same cycle. A decision is 1 when the second operand won and 0 otherwise. In scalar mode one bit enters per operation, and in lane mode two bits enter. The register keeps the survivor history without extra instructions. A synchronous clear empties the history before a new trellis.

Operation select `op` is three bits:
- `op[0]`: 1 selects minimum, 0 selects maximum.
- `op[1]`: 1 selects the dual 16-bit lane mode.
- `op[2]`: 1 records the decision in the traceback register.

Top module: `vit_cmp_sel`

## Requirements
- R1: While `rst_n` is low, `res` and `tb` are zero at every clock edge.
- R2: When `en` is high with `op[1]`=0 and `op[0]`=0, `res` becomes, one clock later, the signed maximum of `opa` and `opb` taken over all 40 bits, guard bits included.
- R3: When `en` is high with `op[1]`=0 and `op[0]`=1, `res` becomes, one clock later, the signed 40-bit minimum of `opa` and `opb`.
- R4: When the two compared values are equal, `opa` is selected and the recorded decision is 0.
- R5: When `op[1]`=1, bits [15:0] and bits [31:16] are compared as independent signed 16-bit lanes, and each lane's winner lands in the same bit positions of `res`. Bits [39:32] of `res` are the sign extension of the high-lane result.
- R6: With `op[2]`=1 and `op[1]`=0, `tb` becomes `{tb[14:0], d}` one clock later, where d=1 when `opb` was selected; the old bit 15 is discarded.
- R7: With `op[2]`=1 and `op[1]`=1, `tb` becomes `{tb[13:0], d_hi, d_lo}`, with the low lane's decision in bit 0 and the high lane's decision in bit 1.
- R8: An operation with `op[2]`=0 leaves `tb` unchanged, and a cycle with `en` low leaves both `res` and `tb` unchanged.
- R9: `tb_clr` high at a clock edge sets `tb` to zero and takes precedence over a shift in the same cycle. A concurrent enabled operation still updates `res`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Perform the operation selected by `op` |
| op | input | 3 | {record, lanes, min} operation select |
| tb_clr | input | 1 | Synchronous clear of the traceback register |
| opa | input | 40 | First operand, kept on a tie |
| opb | input | 40 | Second operand, decision 1 when chosen |
| res | output | 40 | Registered selected value |
| tb | output | 16 | Traceback shift register |

## Verification
A wrong comparison shows on `res` on the clock after the operation. A decision bit of the wrong polarity or in the wrong position shows on `tb` at that same edge. A traceback register that shifts by the wrong amount, shifts when it should hold, or leaks a stale bit is not always visible at once. It becomes visible as soon as the bench compares the whole register after a known sequence of decisions. Running more than sixteen decisions exposes a bit 15 that is not discarded. Sign and guard-bit errors only appear with operands whose signs differ, so the stimulus mixes them in both modes.

// File: rtl/vit_cmp_sel.sv
module vit_cmp_sel #(
  parameter int ACC_W  = 40,
  parameter int LANE_W = 16,
  parameter int TB_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [2:0]       op,
  input  logic             tb_clr,
  input  logic [ACC_W-1:0] opa,
  input  logic [ACC_W-1:0] opb,
  output logic [ACC_W-1:0] res,
  output logic [TB_W-1:0]  tb
);
  localparam int NLANE  = 2;
  localparam int GUARD_W = ACC_W - NLANE*LANE_W;

  wire is_min  = op[0];
  wire is_simd = op[1];
  wire is_vit  = op[2];

  wire s_lt   = $signed(opb) < $signed(opa);
  wire s_gt   = $signed(opb) > $signed(opa);
  wire s_pick = is_min ? s_lt : s_gt;

  logic [NLANE-1:0]        l_pick;
  logic [NLANE*LANE_W-1:0] l_res;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    wire [LANE_W-1:0] la = opa[i*LANE_W +: LANE_W];
    wire [LANE_W-1:0] lb = opb[i*LANE_W +: LANE_W];
    wire lt = $signed(lb) < $signed(la);
    wire gt = $signed(lb) > $signed(la);
    assign l_pick[i] = is_min ? lt : gt;
    assign l_res[i*LANE_W +: LANE_W] = l_pick[i] ? lb : la;
  end

  wire [ACC_W-1:0] simd_res = {{GUARD_W{l_res[NLANE*LANE_W-1]}}, l_res};
  wire [ACC_W-1:0] nxt_res  = is_simd ? simd_res : (s_pick ? opb : opa);
  wire [TB_W-1:0]  nxt_tb   = is_simd ? {tb[TB_W-NLANE-1:0], l_pick}
                                      : {tb[TB_W-2:0], s_pick};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res <= '0;
      tb  <= '0;
    end else begin
      if (en) res <= nxt_res;
      if (tb_clr)             tb <= '0;
      else if (en && is_vit)  tb <= nxt_tb;
    end
  end
endmodule

module vit_cmp_sel_chk #(
  parameter int ACC_W  = 40,
  parameter int LANE_W = 16,
  parameter int TB_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [2:0]       op,
  input logic             tb_clr,
  input logic [ACC_W-1:0] opa,
  input logic [ACC_W-1:0] opb,
  input logic [ACC_W-1:0] res,
  input logic [TB_W-1:0]  tb
);
  assert_max_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op[1:0] == 2'b00) |=> ($signed(res) >= $signed($past(opa)) &&
                                  $signed(res) >= $signed($past(opb)) &&
                                  (res == $past(opa) || res == $past(opb))));

  assert_min_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op[1:0] == 2'b01) |=> ($signed(res) <= $signed($past(opa)) &&
                                  $signed(res) <= $signed($past(opb)) &&
                                  (res == $past(opa) || res == $past(opb))));

  assert_tie_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op[2:1] == 2'b10 && !tb_clr && opa == opb) |=> (tb[0] == 1'b0 && res == $past(opa)));

  assert_scalar_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op[2:1] == 2'b10 && !tb_clr) |=> tb[TB_W-1:1] == $past(tb[TB_W-2:0]));

  assert_lane_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op[2:1] == 2'b11 && !tb_clr) |=> tb[TB_W-1:2] == $past(tb[TB_W-3:0]));

  assert_tb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((!en || !op[2]) && !tb_clr) |=> $stable(tb));

  assert_res_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(res));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tb_clr |=> tb == '0);
endmodule

bind vit_cmp_sel vit_cmp_sel_chk #(.ACC_W(ACC_W), .LANE_W(LANE_W), .TB_W(TB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .op(op), .tb_clr(tb_clr),
  .opa(opa), .opb(opb), .res(res), .tb(tb)
);

// File: tb/vit_cmp_sel_bench.sv
module vit_cmp_sel_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        en = 0;
  logic [2:0]  op = '0;
  logic        tb_clr = 0;
  logic [39:0] opa = '0, opb = '0;
  logic [39:0] res;
  logic [15:0] tb;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_tb = '0;
  logic [39:0] exp_res = '0;

  always #5 clk = ~clk;

  vit_cmp_sel u_vit_cmp_sel (.clk(clk), .rst_n(rst_n), .en(en), .op(op), .tb_clr(tb_clr),
                             .opa(opa), .opb(opb), .res(res), .tb(tb));

  task automatic chk40(string tag, logic [39:0] act, logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk16(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic pick(logic signed [39:0] a, logic signed [39:0] b, logic mn);
    return mn ? (b < a) : (b > a);
  endfunction

  function automatic logic lpick(logic signed [15:0] a, logic signed [15:0] b, logic mn);
    return mn ? (b < a) : (b > a);
  endfunction

  // Apply one operation, update the bench model, check both outputs a clock later
  task automatic apply(string tag, logic [39:0] a, logic [39:0] b, logic [2:0] o, logic clr);
    logic d, dl, dh;
    logic [15:0] lo, hi;
    @(negedge clk);
    opa = a; opb = b; op = o; en = 1; tb_clr = clr;
    if (o[1]) begin
      dl = lpick(a[15:0], b[15:0], o[0]);
      dh = lpick(a[31:16], b[31:16], o[0]);
      lo = dl ? b[15:0] : a[15:0];
      hi = dh ? b[31:16] : a[31:16];
      exp_res = {{8{hi[15]}}, hi, lo};
      if (o[2]) exp_tb = {exp_tb[13:0], dh, dl};
    end else begin
      d = pick(a, b, o[0]);
      exp_res = d ? b : a;
      if (o[2]) exp_tb = {exp_tb[14:0], d};
    end
    if (clr) exp_tb = '0;
    @(negedge clk);
    en = 0; tb_clr = 0;
    chk40({tag, " res"}, res, exp_res);
    chk16({tag, " tb"}, tb, exp_tb);
  endtask

  task automatic t_reset;
    @(negedge clk);
    opa = 40'h12_3456_789A; opb = 40'h7F_FFFF_FFFF; en = 1; op = 3'b100;
    @(negedge clk);
    chk40("R1 res in reset", res, '0);
    chk16("R1 tb in reset", tb, '0);
    en = 0;
    rst_n = 1;
  endtask

  task automatic t_scalar;
    apply("R2 max guard sign", 40'hFF_0000_0000, 40'h00_0000_0001, 3'b000, 0);
    chk40("R2 max value", res, 40'h00_0000_0001);
    apply("R2 max both negative", 40'hFF_FFFF_FFFE, 40'hFF_FFFF_FFFF, 3'b000, 0);
    apply("R2 max guard only", 40'h01_0000_0000, 40'h00_FFFF_FFFF, 3'b000, 0);
    chk40("R2 guard bits count", res, 40'h01_0000_0000);
    apply("R3 min guard sign", 40'h00_0000_0001, 40'h80_0000_0000, 3'b001, 0);
    chk40("R3 min value", res, 40'h80_0000_0000);
    apply("R3 min positive", 40'h00_0000_0005, 40'h00_0000_0009, 3'b001, 0);
  endtask

  task automatic t_tie;
    apply("R4 clear before tie", 40'h0, 40'h0, 3'b000, 1);
    apply("R4 tie max", 40'h00_1234_0000, 40'h00_1234_0000, 3'b100, 0);
    chk16("R4 tie decision 0", tb, 16'h0000);
    apply("R4 tie min", 40'hFF_8000_0000, 40'hFF_8000_0000, 3'b101, 0);
    chk16("R4 tie min decision 0", tb, 16'h0000);
  endtask

  task automatic t_simd;
    apply("R5 lanes max", 40'h00_7FFF_8000, 40'h00_8000_0001, 3'b010, 0);
    chk40("R5 lanes max value", res, 40'h00_7FFF_0001);
    apply("R5 lanes min sign ext", 40'h00_0001_0005, 40'h00_FFFF_0007, 3'b011, 0);
    chk40("R5 lanes min value", res, 40'hFF_FFFF_0005);
    apply("R5 guard ignored", 40'h7F_1000_2000, 40'h80_1000_2000, 3'b010, 0);
    chk40("R5 tie lanes from opa", res, 40'h00_1000_2000);
  endtask

  task automatic t_viterbi;
    apply("R6 clear", 40'h0, 40'h0, 3'b000, 1);
    apply("R6 b wins", 40'h00_0000_0001, 40'h00_0000_0002, 3'b100, 0);
    apply("R6 a wins", 40'h00_0000_0009, 40'h00_0000_0002, 3'b100, 0);
    apply("R6 tie", 40'h00_0000_0003, 40'h00_0000_0003, 3'b100, 0);
    apply("R6 min b wins", 40'h00_0000_0003, 40'hFF_0000_0003, 3'b101, 0);
    chk16("R6 sequence 1001", tb, 16'h0009);
    for (int i = 0; i < 17; i++)
      apply("R6 fill ones", 40'h0, 40'h1, 3'b100, 0);
    chk16("R6 msb discarded", tb, 16'hFFFF);
    apply("R7 clear", 40'h0, 40'h0, 3'b000, 1);
    apply("R7 low b high a", 40'h00_0005_0001, 40'h00_0001_0009, 3'b110, 0);
    chk16("R7 low lane in bit0", tb, 16'h0001);
    apply("R7 low a high b", 40'h00_0001_0009, 40'h00_0005_0001, 3'b110, 0);
    chk16("R7 two bits per op", tb, 16'h0006);
    apply("R7 min both b", 40'h00_0005_0005, 40'h00_FFFF_8000, 3'b111, 0);
    chk16("R7 min both", tb, 16'h001B);
  endtask

  task automatic t_hold;
    logic [39:0] r0;
    logic [15:0] t0;
    apply("R8 plain max no shift", 40'h0, 40'h00_0000_0004, 3'b000, 0);
    chk16("R8 tb unchanged by plain op", tb, 16'h001B);
    apply("R8 plain lanes no shift", 40'h0, 40'h00_0001_0001, 3'b011, 0);
    chk16("R8 tb unchanged by lane op", tb, 16'h001B);
    r0 = res; t0 = tb;
    @(negedge clk);
    opa = 40'h7F_FFFF_FFFF; opb = 40'h00_0000_0000; op = 3'b100; en = 0;
    @(negedge clk);
    chk40("R8 en low holds res", res, r0);
    chk16("R8 en low holds tb", tb, t0);
  endtask

  task automatic t_clear;
    apply("R9 clear beats shift", 40'h00_0000_0001, 40'h00_0000_0007, 3'b100, 1);
    chk40("R9 res still updates", res, 40'h00_0000_0007);
    chk16("R9 tb zero", tb, 16'h0000);
    apply("R9 shift after clear", 40'h0, 40'h1, 3'b100, 0);
    chk16("R9 fresh history", tb, 16'h0001);
    @(negedge clk);
    tb_clr = 1; en = 0;
    @(negedge clk);
    tb_clr = 0;
    chk16("R9 clear without en", tb, 16'h0000);
    exp_tb = '0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_scalar();
    t_tie();
    t_simd();
    t_viterbi();
    t_hold();
    t_clear();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule